// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block picks one interrupt out of several candidates and hands it to a CPU. The candidates are a non-maskable interrupt, a user break request, a debug-port interrupt and a set of ordinary sources. Each ordinary source carries a programmable priority level from 1 to 15, and level 0 turns the source off. The chosen request is compared with a 4-bit CPU mask. When the request wins and the CPU reports that it is at an instruction boundary, the block runs a fixed entry sequence:

1. Save the status word.
2. Save the program counter.
3. Load the accepted level into the mask.
4. Issue the vector number with a one-cycle read strobe.
5. Pulse a branch strobe.

An active-low request pin reports that an acceptable request is waiting. Each ordinary source is either level-sensed or edge-sensed, chosen by parameter. An edge-sensed source latches its rising edges into a status flag, and software clears that flag by writing a 1 to it. Stack memory, instruction execution and the vector table are modelled only as strobes and computed vector numbers.

Top module: `prio_intc`

## Requirements
- R1: After power-on reset the request pin is high, the mask reads 15, all edge flags are 0, and no save, vector-read or branch strobe is active.
- R2: A rising edge on the non-maskable input is accepted even when the mask is 15. It gets vector 11 and loads the mask with 15.
- R3: An ordinary request of level L is accepted only when L is strictly greater than the mask. A level-1 request is therefore accepted only when the mask is 0. Source i uses vector 64+i.
- R4: Candidates are checked in a fixed order: the non-maskable interrupt first, then user break (vector 12), then the debug-port interrupt (vector 14), then ordinary levels from 15 down to 1. User break and the debug-port interrupt each rank as level 15, so a mask of 15 blocks them.
- R5: When several ordinary sources share the highest level, the lowest-numbered source wins.
- R6: Acceptance takes one clock edge. The next five cycles then run in this order:
  - the status word {28'b0, mask} appears on save_data with save_we high;
  - pc_in appears on save_data with save_we high;
  - the mask is loaded with the accepted level;
  - vec_rd pulses with vec_num valid;
  - branch_go pulses.
- R7: The request pin is driven low on the edge after an acceptable request is present, and it returns high once no pending request exceeds the mask.
- R8: Edge-sensed sources (2 and 3 by default) set their flag on a rising input. A 1 written to a flag clears it, but a new edge in the same cycle keeps the flag set. Level-sensed sources never set a flag.
- R9: After an edge-sensed source is accepted, the request pin stays low until that source's flag is cleared. It goes high one edge after the clear.
- R10: If a higher-level request is pending when the entry sequence ends, the request pin stays low.
- R11: A manual reset clears all edge flags and sets the mask to 15, just as power-on reset does.
- R12: Nothing is accepted while cpu_ready is low. CPU writes to the mask are ignored while the entry sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| man_rst_n | input | 1 | Manual reset, active low, asynchronous |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensed |
| brk_req | input | 1 | User break request, level 15 |
| dbg_req | input | 1 | Debug-port interrupt request, level 15 |
| src_req | input | N_SRC | Ordinary request inputs |
| src_lvl | input | 4*N_SRC | Priority level of each source, 0 disables it |
| flag_clr_we | input | 1 | Strobe that clears edge flags |
| flag_clr_bits | input | N_SRC | Flags to clear (1 clears) |
| edge_flags | output | N_SRC | Edge status flags |
| cpu_ready | input | 1 | CPU can take an interrupt this cycle |
| pc_in | input | 32 | Program counter to save |
| mask_we | input | 1 | CPU write strobe for the mask |
| mask_wdata | input | 4 | New mask value |
| cpu_mask | output | 4 | Current interrupt mask |
| irq_out_n | output | 1 | Request pin, active low |
| seq_busy | output | 1 | Entry sequence in progress |
| save_we | output | 1 | Stack write strobe |
| save_data | output | 32 | Word to push onto the stack |
| vec_rd | output | 1 | Vector read strobe |
| vec_num | output | 8 | Vector number |
| branch_go | output | 1 | Branch to the handler |

## Verification
The core of the bench sweeps one ordinary source over every level from 1 to 15 against every mask value from 0 to 15. This checks the strict comparison at each boundary, including the level-1 and mask-15 corners, and it checks the request pin level for each pair. Stacked requests of every kind are then removed one at a time, which shows the check order and separates the three fixed-vector sources from the ordinary ones. Pairs of sources, first at different levels and then at equal levels, show that a higher level wins and that a tie goes to the lower-numbered source. Edge-sensed stimulus covers rising edges, a held input, a clear in the same cycle as a new edge, and a clear after acceptance, which shows the pin-release rule apart from the ordinary mask-based release.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int LVL_W = 4;
    localparam logic [LVL_W-1:0] LVL_TOP = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE_SR,
        ST_SAVE_PC,
        ST_LOAD_MASK,
        ST_VEC_RD,
        ST_BRANCH
    } seq_state_e;
endpackage

// File: rtl/intc_edge_flags.sv
module intc_edge_flags #(
    parameter int N_SRC = 4,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_req,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] clr_bits,
    output logic [N_SRC-1:0] flags,
    output logic [N_SRC-1:0] src_act
);
    typedef struct packed {
        logic [N_SRC-1:0] prev;
        logic [N_SRC-1:0] flags;
    } edge_regs_t;

    edge_regs_t r_d, r_q;
    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] clr_mask;

    always_comb begin
        r_d      = r_q;
        rise     = src_req & ~r_q.prev & EDGE_MASK;
        clr_mask = clr_we ? clr_bits : '0;
        r_d.prev = src_req;
        r_d.flags = (r_q.flags & ~clr_mask) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign flags   = r_q.flags;
    assign src_act = (r_q.flags & EDGE_MASK) | (src_req & ~EDGE_MASK);

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((r_q.flags & $past(rise)) == $past(rise))); // R8
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((r_q.flags & $past(clr_bits & ~rise)) == '0)); // R8
endmodule

// File: rtl/intc_select.sv
module intc_select
    import prio_intc_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    parameter logic [N_SRC-1:0] EDGE_MASK = '0,
    parameter logic [VEC_W-1:0] VEC_NMI  = 8'd11,
    parameter logic [VEC_W-1:0] VEC_BRK  = 8'd12,
    parameter logic [VEC_W-1:0] VEC_DBG  = 8'd14,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'd64,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   nmi_pend,
    input  logic                   brk_req,
    input  logic                   dbg_req,
    input  logic [N_SRC-1:0]       src_act,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    input  logic [LVL_W-1:0]       mask,
    output logic                   win_valid,
    output logic                   win_nmi,
    output logic                   win_edge,
    output logic [LVL_W-1:0]       win_lvl,
    output logic [VEC_W-1:0]       win_vec,
    output logic [IDX_W-1:0]       win_idx
);
    logic [LVL_W-1:0] best_lvl;
    logic [IDX_W-1:0] best_idx;

    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_act[i] && (src_lvl[i*LVL_W +: LVL_W] > best_lvl)) begin
                best_lvl = src_lvl[i*LVL_W +: LVL_W];
                best_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        win_valid = 1'b0;
        win_nmi   = 1'b0;
        win_edge  = 1'b0;
        win_lvl   = LVL_TOP;
        win_vec   = '0;
        win_idx   = '0;
        if (nmi_pend) begin
            win_valid = 1'b1;
            win_nmi   = 1'b1;
            win_vec   = VEC_NMI;
        end else if (brk_req && (mask < LVL_TOP)) begin
            win_valid = 1'b1;
            win_vec   = VEC_BRK;
        end else if (dbg_req && (mask < LVL_TOP)) begin
            win_valid = 1'b1;
            win_vec   = VEC_DBG;
        end else if (best_lvl > mask) begin
            win_valid = 1'b1;
            win_lvl   = best_lvl;
            win_idx   = best_idx;
            win_edge  = EDGE_MASK[best_idx];
            win_vec   = VEC_BASE + VEC_W'(best_idx);
        end
    end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int N_SRC = 4,
    parameter int VEC_W = 8,
    parameter int PC_W  = 32,
    parameter logic [N_SRC-1:0] EDGE_MASK = 4'b1100,
    parameter logic [VEC_W-1:0] VEC_NMI  = 8'd11,
    parameter logic [VEC_W-1:0] VEC_BRK  = 8'd12,
    parameter logic [VEC_W-1:0] VEC_DBG  = 8'd14,
    parameter logic [VEC_W-1:0] VEC_BASE = 8'd64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   man_rst_n,
    input  logic                   nmi_in,
    input  logic                   brk_req,
    input  logic                   dbg_req,
    input  logic [N_SRC-1:0]       src_req,
    input  logic [N_SRC*LVL_W-1:0] src_lvl,
    input  logic                   flag_clr_we,
    input  logic [N_SRC-1:0]       flag_clr_bits,
    output logic [N_SRC-1:0]       edge_flags,
    input  logic                   cpu_ready,
    input  logic [PC_W-1:0]        pc_in,
    input  logic                   mask_we,
    input  logic [LVL_W-1:0]       mask_wdata,
    output logic [LVL_W-1:0]       cpu_mask,
    output logic                   irq_out_n,
    output logic                   seq_busy,
    output logic                   save_we,
    output logic [PC_W-1:0]        save_data,
    output logic                   vec_rd,
    output logic [VEC_W-1:0]       vec_num,
    output logic                   branch_go
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        seq_state_e       state;
        logic [LVL_W-1:0] mask;
        logic             nmi_prev;
        logic             nmi_pend;
        logic             acc_nmi;
        logic             acc_edge;
        logic [LVL_W-1:0] acc_lvl;
        logic [VEC_W-1:0] acc_vec;
        logic [IDX_W-1:0] acc_idx;
        logic             hold;
        logic             irq_n;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic rst_all_n;

    logic [N_SRC-1:0] src_act;
    logic             win_valid, win_nmi, win_edge;
    logic [LVL_W-1:0] win_lvl;
    logic [VEC_W-1:0] win_vec;
    logic [IDX_W-1:0] win_idx;
    logic             accept;
    logic             hold_live;

    assign rst_all_n = rst_n & man_rst_n;

    intc_edge_flags #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_flags (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .src_req  (src_req),
        .clr_we   (flag_clr_we),
        .clr_bits (flag_clr_bits),
        .flags    (edge_flags),
        .src_act  (src_act)
    );

    intc_select #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .EDGE_MASK(EDGE_MASK),
        .VEC_NMI(VEC_NMI), .VEC_BRK(VEC_BRK), .VEC_DBG(VEC_DBG), .VEC_BASE(VEC_BASE)
    ) u_sel (
        .nmi_pend  (s_q.nmi_pend),
        .brk_req   (brk_req),
        .dbg_req   (dbg_req),
        .src_act   (src_act),
        .src_lvl   (src_lvl),
        .mask      (s_q.mask),
        .win_valid (win_valid),
        .win_nmi   (win_nmi),
        .win_edge  (win_edge),
        .win_lvl   (win_lvl),
        .win_vec   (win_vec),
        .win_idx   (win_idx)
    );

    always_comb begin
        s_d        = s_q;
        accept     = (s_q.state == ST_IDLE) && cpu_ready && win_valid;
        hold_live  = s_q.hold && edge_flags[s_q.acc_idx];
        s_d.nmi_prev = nmi_in;
        if (nmi_in && !s_q.nmi_prev) s_d.nmi_pend = 1'b1;
        if (s_q.hold && !edge_flags[s_q.acc_idx]) s_d.hold = 1'b0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (accept) begin
                    s_d.state    = ST_SAVE_SR;
                    s_d.acc_nmi  = win_nmi;
                    s_d.acc_edge = win_edge;
                    s_d.acc_lvl  = win_lvl;
                    s_d.acc_vec  = win_vec;
                    s_d.acc_idx  = win_idx;
                    s_d.hold     = win_edge;
                    if (win_nmi) s_d.nmi_pend = 1'b0;
                end else if (mask_we) begin
                    s_d.mask = mask_wdata;
                end
            end
            ST_SAVE_SR:   s_d.state = ST_SAVE_PC;
            ST_SAVE_PC:   s_d.state = ST_LOAD_MASK;
            ST_LOAD_MASK: begin
                s_d.state = ST_VEC_RD;
                s_d.mask  = s_q.acc_lvl;
            end
            ST_VEC_RD:    s_d.state = ST_BRANCH;
            ST_BRANCH:    s_d.state = ST_IDLE;
            default:      s_d.state = ST_IDLE;
        endcase

        s_d.irq_n = !(win_valid || hold_live);
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            s_q       <= '0;
            s_q.state <= ST_IDLE;
            s_q.mask  <= LVL_TOP;
            s_q.irq_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_mask  = s_q.mask;
    assign irq_out_n = s_q.irq_n;
    assign seq_busy  = (s_q.state != ST_IDLE);
    assign save_we   = (s_q.state == ST_SAVE_SR) || (s_q.state == ST_SAVE_PC);
    assign save_data = (s_q.state == ST_SAVE_SR) ? PC_W'(s_q.mask) : pc_in;
    assign vec_rd    = (s_q.state == ST_VEC_RD);
    assign vec_num   = s_q.acc_vec;
    assign branch_go = (s_q.state == ST_BRANCH);

    AST_ACCEPT_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_all_n)
        (s_q.state == ST_SAVE_SR) |-> (s_q.acc_nmi || (s_q.acc_lvl > s_q.mask))); // R3
    AST_NMI_WINS: assert property (@(posedge clk) disable iff (!rst_all_n)
        ((s_q.state == ST_IDLE) && cpu_ready && s_q.nmi_pend) |=> ((s_q.state == ST_SAVE_SR) && s_q.acc_nmi)); // R2
    AST_SR_THEN_PC: assert property (@(posedge clk) disable iff (!rst_all_n)
        (s_q.state == ST_SAVE_SR) |=> (s_q.state == ST_SAVE_PC)); // R6
    AST_PC_THEN_LOAD: assert property (@(posedge clk) disable iff (!rst_all_n)
        (s_q.state == ST_SAVE_PC) |=> (s_q.state == ST_LOAD_MASK)); // R6
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_all_n)
        (s_q.state == ST_LOAD_MASK) |=> ((s_q.mask == $past(s_q.acc_lvl)) && vec_rd)); // R6
    AST_VEC_THEN_BRANCH: assert property (@(posedge clk) disable iff (!rst_all_n)
        vec_rd |=> branch_go); // R6
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_all_n)
        $onehot0({save_we, vec_rd, branch_go})); // R6
    AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_all_n)
        ((s_q.state != ST_IDLE) && (s_q.state != ST_LOAD_MASK)) |=> $stable(s_q.mask)); // R12
    AST_NO_ACCEPT_UNREADY: assert property (@(posedge clk) disable iff (!rst_all_n)
        ((s_q.state == ST_IDLE) && !cpu_ready) |=> (s_q.state == ST_IDLE)); // R12
    AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_all_n)
        win_valid |=> !irq_out_n); // R7
endmodule

// File: tb/prio_intc_tb_top.sv
module prio_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0, man_rst_n = 1'b1;
    logic        nmi_in = 1'b0, brk_req = 1'b0, dbg_req = 1'b0;
    logic [3:0]  src_req = '0;
    logic [15:0] src_lvl = '0;
    logic        flag_clr_we = 1'b0;
    logic [3:0]  flag_clr_bits = '0;
    logic [3:0]  edge_flags;
    logic        cpu_ready = 1'b0;
    logic [31:0] pc_in = 32'h0000_A5C4;
    logic        mask_we = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic [3:0]  cpu_mask;
    logic        irq_out_n, seq_busy, save_we, vec_rd, branch_go;
    logic [31:0] save_data;
    logic [7:0]  vec_num;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_intc dut_i (
        .clk(clk), .rst_n(rst_n), .man_rst_n(man_rst_n), .nmi_in(nmi_in),
        .brk_req(brk_req), .dbg_req(dbg_req), .src_req(src_req), .src_lvl(src_lvl),
        .flag_clr_we(flag_clr_we), .flag_clr_bits(flag_clr_bits), .edge_flags(edge_flags),
        .cpu_ready(cpu_ready), .pc_in(pc_in), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .cpu_mask(cpu_mask), .irq_out_n(irq_out_n), .seq_busy(seq_busy), .save_we(save_we),
        .save_data(save_data), .vec_rd(vec_rd), .vec_num(vec_num), .branch_go(branch_go)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_mask(input logic [3:0] m);
        mask_we = 1'b1;
        mask_wdata = m;
        step();
        mask_we = 1'b0;
    endtask

    // Full entry sequence; mask writes are attempted mid-sequence (R12)
    task automatic run_seq(input string req, input logic [7:0] exp_vec,
                           input logic [3:0] exp_lvl, input logic [3:0] sr_mask);
        cpu_ready = 1'b1;
        step();
        cpu_ready = 1'b0;
        chk({req, " R6 save sr"}, {seq_busy, save_we, save_data}, {2'b11, 28'h0, sr_mask});
        mask_we = 1'b1;
        mask_wdata = 4'd0;
        step();
        chk({req, " R6 save pc"}, {save_we, save_data}, {1'b1, pc_in});
        step();
        mask_we = 1'b0;
        step();
        chk({req, " R6 vector"}, {vec_rd, vec_num}, {1'b1, exp_vec});
        chk({req, " R12 mask loaded"}, cpu_mask, exp_lvl);
        step();
        chk({req, " R6 branch"}, {branch_go, vec_rd, save_we}, 3'b100);
        step();
        chk({req, " R6 idle"}, seq_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 pin", irq_out_n, 1);
        chk("R1 mask", cpu_mask, 15);
        chk("R1 flags", edge_flags, 0);
        chk("R1 strobes", {save_we, vec_rd, branch_go, seq_busy}, 0);

        // R12 no acceptance while cpu_ready low
        set_mask(0);
        src_lvl[3:0] = 4'd5;
        src_req[0] = 1'b1;
        step(); step(); step();
        chk("R12 not ready", {seq_busy, save_we}, 0);
        chk("R7 pin low", irq_out_n, 0);
        src_req = '0;

        // R3 / R7 exhaustive sweep of mask against level on source 0
        for (int m = 0; m < 16; m++) begin
            for (int l = 1; l < 16; l++) begin
                src_req = '0;
                set_mask(4'(m));
                src_lvl[3:0] = 4'(l);
                src_req[0] = 1'b1;
                step(); step();
                chk("R7 pin vs mask", irq_out_n, (l > m) ? 0 : 1);
                if (l > m) begin
                    run_seq("R3", 8'd64, 4'(l), 4'(m));
                end else begin
                    cpu_ready = 1'b1;
                    step();
                    cpu_ready = 1'b0;
                    chk("R3 rejected", {save_we, seq_busy}, 0);
                end
                src_req = '0;
            end
        end
        step();
        chk("R7 pin released", irq_out_n, 1);

        // R4 fixed check order
        set_mask(0);
        src_lvl[3:0] = 4'd15;
        src_req[0] = 1'b1;
        brk_req = 1'b1;
        dbg_req = 1'b1;
        nmi_in = 1'b1;
        step();
        run_seq("R4 nmi first", 8'd11, 4'd15, 4'd0);
        set_mask(0);
        run_seq("R4 break second", 8'd12, 4'd15, 4'd0);
        brk_req = 1'b0;
        set_mask(0);
        run_seq("R4 debug third", 8'd14, 4'd15, 4'd0);
        dbg_req = 1'b0;
        set_mask(0);
        run_seq("R4 ordinary last", 8'd64, 4'd15, 4'd0);
        nmi_in = 1'b0;

        // R4 mask 15 blocks break; R2 NMI ignores mask
        brk_req = 1'b1;
        cpu_ready = 1'b1;
        step();
        cpu_ready = 1'b0;
        chk("R4 break masked at 15", seq_busy, 0);
        nmi_in = 1'b1;
        step();
        run_seq("R2 nmi at mask 15", 8'd11, 4'd15, 4'd15);
        nmi_in = 1'b0;
        brk_req = 1'b0;
        src_req = '0;

        // R5 level then index priority
        set_mask(0);
        src_lvl = 16'h0075;
        src_req = 4'b0011;
        run_seq("R5 higher level", 8'd65, 4'd7, 4'd0);
        set_mask(0);
        src_lvl = 16'h0055;
        run_seq("R5 lower index on tie", 8'd64, 4'd5, 4'd0);
        src_req = '0;
        src_lvl = '0;

        // R8 edge flags
        src_req[2] = 1'b1;
        step();
        chk("R8 edge sets flag", edge_flags, 4'b0100);
        src_req[0] = 1'b1;
        step();
        chk("R8 level source no flag", edge_flags, 4'b0100);
        flag_clr_we = 1'b1;
        flag_clr_bits = 4'b0100;
        step();
        flag_clr_we = 1'b0;
        chk("R8 write one clears", edge_flags, 0);
        src_req = '0;
        step();
        src_req[2] = 1'b1;
        flag_clr_we = 1'b1;
        step();
        flag_clr_we = 1'b0;
        chk("R8 set beats clear", edge_flags, 4'b0100);
        src_req = '0;
        flag_clr_we = 1'b1;
        step();
        flag_clr_we = 1'b0;
        chk("R8 cleared again", edge_flags, 0);

        // R9 edge-sensed pin release on flag clear
        src_lvl = 16'h0300;
        set_mask(0);
        src_req[2] = 1'b1;
        step();
        src_req[2] = 1'b0;
        run_seq("R9 edge accept", 8'd66, 4'd3, 4'd0);
        step();
        chk("R9 pin held", irq_out_n, 0);
        flag_clr_we = 1'b1;
        flag_clr_bits = 4'b0100;
        step();
        flag_clr_we = 1'b0;
        step();
        chk("R9 pin released", irq_out_n, 1);

        // R10 higher request arriving during the sequence keeps pin low
        src_lvl = 16'h0094;
        set_mask(0);
        src_req = 4'b0001;
        cpu_ready = 1'b1;
        step();
        cpu_ready = 1'b0;
        src_req = 4'b0011;
        step(); step(); step(); step(); step();
        chk("R10 idle", seq_busy, 0);
        chk("R10 mask", cpu_mask, 4);
        chk("R10 pin stays low", irq_out_n, 0);
        src_req = '0;
        step(); step();
        chk("R7 released", irq_out_n, 1);

        // R11 manual reset
        src_req[3] = 1'b1;
        set_mask(2);
        chk("R11 flag before", edge_flags, 4'b1000);
        man_rst_n = 1'b0;
        step();
        man_rst_n = 1'b1;
        src_req = '0;
        step();
        chk("R11 flags cleared", edge_flags, 0);
        chk("R11 mask 15", cpu_mask, 15);
        chk("R11 pin high", irq_out_n, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule